// File: doc/BRIEF.md
# Lockable Identification Page Manager

This block serves a separate 128-byte identification page that sits beside the main memory of a serial-bus EEPROM-style slave. The page is addressed with its own device type nibble. The block sits behind the slave's byte engine. It receives decoded transaction events: Start, the device select byte, the two address bytes, each written data byte, each read request and Stop. For every selecting, address or data byte it returns an acknowledge decision. It returns read data and shows whether the page is locked.

A write transaction either writes bytes into the page or issues the one-time lock command. One bit of the high address byte chooses between the two. Written bytes are held in a staging buffer. They reach the page, and a lock takes effect, only when Stop arrives straight after an acknowledged data byte. Any other ending throws the staged bytes away. Once locked, the page refuses all data bytes and reads back as all ones. Only a reset returns it to the unprogrammed, unlocked state.

Top module: `idpage_mgr`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 equal 1011 and bits 3:1 equal the `chip_en` pins. Bit 0 set means read and bit 0 clear means write. A select byte that does not match is answered with `ack`=0, and the address, data, read and Stop events that follow it give no `ack_valid`, no `rd_valid` and no change until the next select byte.
- R2: In a write, the first address byte is the high byte and its bit 2 (address bit 10) picks the lock command when set. The second address byte sets the byte offset from its bits 6:0. All other address bits are ignored, and both address bytes are acknowledged.
- R3: In a page write on an unlocked page, each data byte is acknowledged and staged at the current offset. The offset then advances and wraps from 127 to 0. Staged bytes reach the page only on a Stop that comes directly after an acknowledged data byte.
- R4: A Start, or a new select byte, arriving between the last data byte and Stop discards the staged bytes and the pending lock. The page and the lock state stay unchanged.
- R5: A lock command (address bit 10 = 1) acknowledges its data bytes while unlocked. On a valid Stop it sets `locked` only if an accepted data byte had bit 1 set. A lock command never alters page contents.
- R6: While `locked` is 1, every data byte of a page write or lock command gets `ack`=0 and nothing changes. `locked` never returns to 0 except by reset.
- R7: In a read transaction, each `rd_req` gives `rd_valid` one cycle later with the page byte at the current offset, and the offset advances with a 7-bit wrap. While locked, the byte returned is FFh.
- R8: After reset, `locked`=0, `ack_valid`=0, `rd_valid`=0, and every page byte reads FFh.
- R9: `ack_valid` pulses for exactly one cycle, in the cycle after the select, address or data event it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears page and lock |
| chip_en | input | 3 | Strapped chip-enable value compared against select bits 3:1 |
| start_evt | input | 1 | Start or repeated Start seen on the bus |
| sel_valid | input | 1 | Select byte received |
| sel_byte | input | 8 | Select byte: type nibble, chip enable, read/write |
| addr_valid | input | 1 | Address byte received |
| addr_byte | input | 8 | Address byte, high byte first |
| wdata_valid | input | 1 | Write data byte received |
| wdata | input | 8 | Write data byte |
| rd_req | input | 1 | Master requests the next read byte |
| stop_evt | input | 1 | Stop seen on the bus |
| ack_valid | output | 1 | Acknowledge decision is present |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_valid | output | 1 | Read byte is present |
| rd_data | output | 8 | Read byte |
| locked | output | 1 | Page is permanently locked |

## Verification
The hardest states to reach are a locked page and a lock command whose Stop lands outside the valid slot. Locking is one-way, so the bench runs all of its random page-write traffic first. That traffic mixes valid and discarded endings and includes wrapping bursts. After it come the directed lock attempts: one with bit 1 clear, and one cancelled by a Start before its Stop. Only then does the real lock run, followed by refused writes. A final reset shows the page returning to its unprogrammed contents.

// File: rtl/idpage_pkg.sv
package idpage_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_WRITE,
      ST_READ
   } idp_state_t;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_START,
      EV_SEL,
      EV_ADDR,
      EV_DATA,
      EV_READ,
      EV_STOP
   } idp_ev_t;

endpackage

// File: rtl/idp_seq.sv
module idp_seq
   import idpage_pkg::*;
#(
   parameter int          OFS_W         = 7,
   parameter int          LOCK_HI_BIT   = 2,
   parameter logic [3:0]  TYPE_CODE     = 4'b1011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       chip_en,
   input  logic             start_evt,
   input  logic             sel_valid,
   input  logic [7:0]       sel_byte,
   input  logic             addr_valid,
   input  logic [7:0]       addr_byte,
   input  logic             wdata_valid,
   input  logic             rd_req,
   input  logic             stop_evt,
   input  logic             locked,
   output logic             ack_valid,
   output logic             ack,
   output logic [OFS_W-1:0] ofs,
   output logic             byte_take,
   output logic             stage_clr,
   output logic             rd_fire,
   output logic             commit_page,
   output logic             commit_lock
);

   idp_state_t st_q;
   idp_ev_t    ev;
   logic       hit;
   logic       lock_mode_q;
   logic       last_data_q;
   logic       commit;
   logic       unused_addr;

   assign unused_addr = ^addr_byte;
   assign hit = (sel_byte[7:4] == TYPE_CODE) && (sel_byte[3:1] == chip_en);

   always_comb begin
      if (start_evt)        ev = EV_START;
      else if (sel_valid)   ev = EV_SEL;
      else if (addr_valid)  ev = EV_ADDR;
      else if (wdata_valid) ev = EV_DATA;
      else if (rd_req)      ev = EV_READ;
      else if (stop_evt)    ev = EV_STOP;
      else                  ev = EV_NONE;
   end

   assign byte_take   = (ev == EV_DATA) && (st_q == ST_WRITE) && !locked;
   assign rd_fire     = (ev == EV_READ) && (st_q == ST_READ);
   assign stage_clr   = (ev == EV_START) || (ev == EV_SEL);
   assign commit      = (ev == EV_STOP) && (st_q == ST_WRITE) && last_data_q && !locked;
   assign commit_page = commit && !lock_mode_q;
   assign commit_lock = commit && lock_mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         ofs         <= '0;
         lock_mode_q <= 1'b0;
         last_data_q <= 1'b0;
         ack_valid   <= 1'b0;
         ack         <= 1'b0;
      end else begin
         ack_valid <= 1'b0;
         unique case (ev)
            EV_START: begin
               st_q        <= ST_IDLE;
               last_data_q <= 1'b0;
            end
            EV_SEL: begin
               last_data_q <= 1'b0;
               ack_valid   <= 1'b1;
               ack         <= hit;
               if (!hit)            st_q <= ST_IDLE;
               else if (sel_byte[0]) st_q <= ST_READ;
               else                 st_q <= ST_ADDR_HI;
            end
            EV_ADDR: begin
               if (st_q == ST_ADDR_HI) begin
                  lock_mode_q <= addr_byte[LOCK_HI_BIT];
                  st_q        <= ST_ADDR_LO;
                  ack_valid   <= 1'b1;
                  ack         <= 1'b1;
               end else if (st_q == ST_ADDR_LO) begin
                  ofs       <= addr_byte[OFS_W-1:0];
                  st_q      <= ST_WRITE;
                  ack_valid <= 1'b1;
                  ack       <= 1'b1;
               end
            end
            EV_DATA: begin
               if (st_q == ST_WRITE) begin
                  ack_valid   <= 1'b1;
                  ack         <= !locked;
                  last_data_q <= !locked;
                  if (!locked) ofs <= ofs + 1'b1;
               end
            end
            EV_READ: begin
               last_data_q <= 1'b0;
               if (st_q == ST_READ) ofs <= ofs + 1'b1;
            end
            EV_STOP: begin
               st_q        <= ST_IDLE;
               last_data_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/idp_stage.sv
module idp_stage #(
   parameter int PAGE_BYTES    = 128,
   parameter int OFS_W         = 7,
   parameter int LOCK_DATA_BIT = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        take,
   input  logic [OFS_W-1:0]            ofs,
   input  logic [7:0]                  din,
   output logic [PAGE_BYTES-1:0][7:0]  sdata,
   output logic [PAGE_BYTES-1:0]       smask,
   output logic                        arm
);

   genvar gi;
   generate
      for (gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sdata[gi] <= '0;
               smask[gi] <= 1'b0;
            end else if (clr) begin
               smask[gi] <= 1'b0;
            end else if (take && (ofs == OFS_W'(gi))) begin
               sdata[gi] <= din;
               smask[gi] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    arm <= 1'b0;
      else if (clr)  arm <= 1'b0;
      else if (take) arm <= arm | din[LOCK_DATA_BIT];
   end

endmodule

// File: rtl/idp_store.sv
module idp_store #(
   parameter int         PAGE_BYTES   = 128,
   parameter int         OFS_W        = 7,
   parameter logic [7:0] FILL         = 8'hFF,
   parameter bit         HIDE_LOCKED  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit_page,
   input  logic                        commit_lock,
   input  logic [PAGE_BYTES-1:0][7:0]  sdata,
   input  logic [PAGE_BYTES-1:0]       smask,
   input  logic                        arm,
   input  logic                        rd_fire,
   input  logic [OFS_W-1:0]            rd_ofs,
   output logic                        rd_valid,
   output logic [7:0]                  rd_data,
   output logic                        locked
);

   logic [PAGE_BYTES-1:0][7:0] page_q;
   logic [7:0]                 rd_pick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= {PAGE_BYTES{FILL}};
      end else if (commit_page) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (smask[i]) page_q[i] <= sdata[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    locked <= 1'b0;
      else if (commit_lock && arm)   locked <= 1'b1;
   end

   generate
      if (HIDE_LOCKED) begin : g_hide
         assign rd_pick = locked ? FILL : page_q[rd_ofs];
      end else begin : g_show
         assign rd_pick = page_q[rd_ofs];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) rd_data <= rd_pick;
      end
   end

endmodule

// File: rtl/idpage_mgr.sv
module idpage_mgr #(
   parameter int         PAGE_BYTES    = 128,
   parameter int         LOCK_ADDR_BIT = 10,
   parameter int         LOCK_DATA_BIT = 1,
   parameter logic [3:0] TYPE_CODE     = 4'b1011,
   parameter logic [7:0] FILL          = 8'hFF,
   parameter bit         HIDE_LOCKED   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] chip_en,
   input  logic       start_evt,
   input  logic       sel_valid,
   input  logic [7:0] sel_byte,
   input  logic       addr_valid,
   input  logic [7:0] addr_byte,
   input  logic       wdata_valid,
   input  logic [7:0] wdata,
   input  logic       rd_req,
   input  logic       stop_evt,
   output logic       ack_valid,
   output logic       ack,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic       locked
);

   localparam int OFS_W       = $clog2(PAGE_BYTES);
   localparam int LOCK_HI_BIT = LOCK_ADDR_BIT - 8;

   generate
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two from 2 to 256");
      end
      if (LOCK_ADDR_BIT < 8 || LOCK_ADDR_BIT > 15) begin : g_bad_lock_addr
         $error("LOCK_ADDR_BIT must lie in the high address byte");
      end
      if (LOCK_DATA_BIT < 0 || LOCK_DATA_BIT > 7) begin : g_bad_lock_data
         $error("LOCK_DATA_BIT must lie inside a data byte");
      end
   endgenerate

   logic [OFS_W-1:0]            ofs;
   logic                        byte_take;
   logic                        stage_clr;
   logic                        rd_fire;
   logic                        commit_page;
   logic                        commit_lock;
   logic [PAGE_BYTES-1:0][7:0]  sdata;
   logic [PAGE_BYTES-1:0]       smask;
   logic                        arm;

   idp_seq #(
      .OFS_W       (OFS_W),
      .LOCK_HI_BIT (LOCK_HI_BIT),
      .TYPE_CODE   (TYPE_CODE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .chip_en     (chip_en),
      .start_evt   (start_evt),
      .sel_valid   (sel_valid),
      .sel_byte    (sel_byte),
      .addr_valid  (addr_valid),
      .addr_byte   (addr_byte),
      .wdata_valid (wdata_valid),
      .rd_req      (rd_req),
      .stop_evt    (stop_evt),
      .locked      (locked),
      .ack_valid   (ack_valid),
      .ack         (ack),
      .ofs         (ofs),
      .byte_take   (byte_take),
      .stage_clr   (stage_clr),
      .rd_fire     (rd_fire),
      .commit_page (commit_page),
      .commit_lock (commit_lock)
   );

   idp_stage #(
      .PAGE_BYTES    (PAGE_BYTES),
      .OFS_W         (OFS_W),
      .LOCK_DATA_BIT (LOCK_DATA_BIT)
   ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stage_clr),
      .take  (byte_take),
      .ofs   (ofs),
      .din   (wdata),
      .sdata (sdata),
      .smask (smask),
      .arm   (arm)
   );

   idp_store #(
      .PAGE_BYTES  (PAGE_BYTES),
      .OFS_W       (OFS_W),
      .FILL        (FILL),
      .HIDE_LOCKED (HIDE_LOCKED)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_page (commit_page),
      .commit_lock (commit_lock),
      .sdata       (sdata),
      .smask       (smask),
      .arm         (arm),
      .rd_fire     (rd_fire),
      .rd_ofs      (ofs),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .locked      (locked)
   );

endmodule

// File: rtl/idpage_mgr_chk.sv
module idpage_mgr_chk #(
   parameter logic [3:0] TYPE_CODE = 4'b1011,
   parameter logic [7:0] FILL      = 8'hFF
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_evt,
   input logic       sel_valid,
   input logic [7:0] sel_byte,
   input logic       addr_valid,
   input logic       wdata_valid,
   input logic       rd_req,
   input logic       stop_evt,
   input logic       ack_valid,
   input logic       ack,
   input logic       rd_valid,
   input logic [7:0] rd_data,
   input logic       locked
);

   assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && $past(sel_valid) && !$past(start_evt) && ($past(sel_byte[7:4]) != TYPE_CODE)) |-> !ack);

   assert_lock_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(stop_evt));

   assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(locked));

   assert_locked_data_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && $past(wdata_valid) && !$past(sel_valid) && !$past(addr_valid) && $past(locked)) |-> !ack);

   assert_read_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));

   assert_locked_read_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(locked)) |-> (rd_data == FILL));

   assert_ack_after_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(sel_valid || addr_valid || wdata_valid));

endmodule

bind idpage_mgr idpage_mgr_chk #(.TYPE_CODE(TYPE_CODE), .FILL(FILL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_evt   (start_evt),
   .sel_valid   (sel_valid),
   .sel_byte    (sel_byte),
   .addr_valid  (addr_valid),
   .wdata_valid (wdata_valid),
   .rd_req      (rd_req),
   .stop_evt    (stop_evt),
   .ack_valid   (ack_valid),
   .ack         (ack),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .locked      (locked)
);

// File: tb/idpage_mgr_test.sv
module idpage_mgr_test;

   localparam logic [2:0] CE = 3'b101;
   localparam int M_IDLE = 0, M_AHI = 1, M_ALO = 2, M_WR = 3, M_RD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] chip_en = CE;
   logic       start_evt = 0, sel_valid = 0, addr_valid = 0, wdata_valid = 0, rd_req = 0, stop_evt = 0;
   logic [7:0] sel_byte = 0, addr_byte = 0, wdata = 0;
   logic       ack_valid, ack, rd_valid, locked;
   logic [7:0] rd_data;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] ref_page [128];
   logic [7:0] m_stage  [128];
   bit         m_mask   [128];
   bit         ref_locked, m_arm, m_last, m_lockmode;
   int         m_st;
   logic [6:0] m_ptr;

   idpage_mgr uut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start_evt(start_evt),
      .sel_valid(sel_valid), .sel_byte(sel_byte), .addr_valid(addr_valid),
      .addr_byte(addr_byte), .wdata_valid(wdata_valid), .wdata(wdata),
      .rd_req(rd_req), .stop_evt(stop_evt), .ack_valid(ack_valid), .ack(ack),
      .rd_valid(rd_valid), .rd_data(rd_data), .locked(locked)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_stage();
      for (int i = 0; i < 128; i++) m_mask[i] = 0;
      m_arm = 0;
      m_last = 0;
   endtask

   task automatic model_reset();
      for (int i = 0; i < 128; i++) ref_page[i] = 8'hFF;
      ref_locked = 0;
      m_st = M_IDLE;
      m_ptr = 0;
      m_lockmode = 0;
      clear_stage();
   endtask

   task automatic drop_all();
      start_evt = 0; sel_valid = 0; addr_valid = 0; wdata_valid = 0; rd_req = 0; stop_evt = 0;
   endtask

   task automatic do_start();
      @(negedge clk); start_evt = 1;
      @(negedge clk); drop_all();
      m_st = M_IDLE; clear_stage();
   endtask

   task automatic do_stop();
      @(negedge clk); stop_evt = 1;
      @(negedge clk); drop_all();
      if (m_st == M_WR && m_last && !ref_locked) begin
         if (m_lockmode) begin
            if (m_arm) ref_locked = 1;
         end else begin
            for (int i = 0; i < 128; i++) if (m_mask[i]) ref_page[i] = m_stage[i];
         end
      end
      m_st = M_IDLE; m_last = 0;
   endtask

   task automatic send_sel(input logic [3:0] typ, input logic [2:0] ce, input bit rw);
      bit hit;
      hit = (typ == 4'b1011) && (ce == CE);
      @(negedge clk); sel_valid = 1; sel_byte = {typ, ce, rw};
      @(negedge clk); drop_all();
      chk(ack_valid === 1'b1, "R9", "select ack_valid", ack_valid, 1);
      chk(ack === hit, "R1", "select ack", ack, hit);
      clear_stage();
      m_st = !hit ? M_IDLE : (rw ? M_RD : M_AHI);
      @(negedge clk);
      chk(ack_valid === 1'b0, "R9", "ack_valid single pulse", ack_valid, 0);
   endtask

   task automatic send_addr(input logic [7:0] b);
      bit exp_v;
      exp_v = (m_st == M_AHI) || (m_st == M_ALO);
      @(negedge clk); addr_valid = 1; addr_byte = b;
      @(negedge clk); drop_all();
      chk(ack_valid === exp_v, "R2", "address ack_valid", ack_valid, exp_v);
      if (exp_v) chk(ack === 1'b1, "R2", "address ack", ack, 1);
      if (m_st == M_AHI) begin m_lockmode = b[2]; m_st = M_ALO; end
      else if (m_st == M_ALO) begin m_ptr = b[6:0]; m_st = M_WR; end
   endtask

   task automatic send_data(input logic [7:0] b, input string req);
      bit exp_v, exp_a;
      exp_v = (m_st == M_WR);
      exp_a = exp_v && !ref_locked;
      @(negedge clk); wdata_valid = 1; wdata = b;
      @(negedge clk); drop_all();
      chk(ack_valid === exp_v, req, "data ack_valid", ack_valid, exp_v);
      if (exp_v) chk(ack === exp_a, req, "data ack", ack, exp_a);
      if (exp_v) begin
         if (exp_a) begin
            m_stage[m_ptr] = b; m_mask[m_ptr] = 1; m_arm = m_arm | b[1];
            m_ptr = m_ptr + 1; m_last = 1;
         end else m_last = 0;
      end
   endtask

   task automatic read_one(input string req);
      bit exp_v;
      logic [7:0] exp_d;
      exp_v = (m_st == M_RD);
      exp_d = ref_locked ? 8'hFF : ref_page[m_ptr];
      @(negedge clk); rd_req = 1;
      @(negedge clk); drop_all();
      chk(rd_valid === exp_v, req, "rd_valid", rd_valid, exp_v);
      if (exp_v) begin
         chk(rd_data === exp_d, req, $sformatf("rd_data at offset %0d", m_ptr), rd_data, exp_d);
         m_ptr = m_ptr + 1;
      end
      m_last = 0;
   endtask

   task automatic page_write(input logic [6:0] o, input int n, input bit good, input string req);
      do_start();
      send_sel(4'b1011, CE, 0);
      send_addr({$urandom_range(0, 31) & 8'hFB});
      send_addr({1'($urandom_range(0, 1)), o});
      for (int k = 0; k < n; k++) send_data(8'($urandom), req);
      if (!good) do_start();
      do_stop();
   endtask

   task automatic lock_cmd(input logic [7:0] d, input bit good, input string req);
      do_start();
      send_sel(4'b1011, CE, 0);
      send_addr(8'h04 | 8'($urandom_range(0, 255) & 8'hFB));
      send_addr(8'($urandom));
      send_data(d, req);
      if (!good) do_start();
      do_stop();
   endtask

   task automatic rand_read(input logic [6:0] o, input int n, input string req);
      do_start();
      send_sel(4'b1011, CE, 0);
      send_addr(8'($urandom) & 8'hFB);
      send_addr({1'b0, o});
      do_start();
      send_sel(4'b1011, CE, 1);
      for (int k = 0; k < n; k++) read_one(req);
      do_stop();
   endtask

   task automatic apply_reset();
      @(negedge clk); rst_n = 0; drop_all();
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      @(negedge clk);
      chk(locked === 1'b0, "R8", "locked after reset", locked, 0);
      chk(ack_valid === 1'b0, "R8", "ack_valid after reset", ack_valid, 0);
      chk(rd_valid === 1'b0, "R8", "rd_valid after reset", rd_valid, 0);
   endtask

   initial begin
      void'($urandom(32'd1729));
      model_reset();
      apply_reset();

      rand_read(7'd0, 6, "R8");
      rand_read(7'd125, 5, "R8");

      page_write(7'd126, 4, 1, "R3");
      rand_read(7'd126, 4, "R3");
      rand_read(7'd127, 3, "R7");

      page_write(7'd10, 3, 0, "R4");
      rand_read(7'd10, 3, "R4");
      do_start();
      send_sel(4'b1011, CE, 0);
      send_addr(8'h00);
      send_addr(8'h30);
      send_data(8'hA5, "R4");
      send_sel(4'b1011, CE, 0);
      do_stop();
      rand_read(7'd48, 1, "R4");

      for (int it = 0; it < 30; it++) begin
         page_write(7'($urandom), $urandom_range(1, 20), $urandom_range(0, 3) != 0, "R3");
         rand_read(7'($urandom), 8, "R7");
      end
      page_write(7'd0, 130, 1, "R3");
      rand_read(7'd0, 128, "R3");

      do_start();
      send_sel(4'b1010, CE, 0);
      send_addr(8'h00);
      send_addr(8'h05);
      send_data(8'h11, "R1");
      do_stop();
      do_start();
      send_sel(4'b1011, CE ^ 3'b001, 0);
      send_addr(8'h00);
      send_data(8'h22, "R1");
      do_stop();
      do_start();
      send_sel(4'b1011, CE ^ 3'b100, 1);
      read_one("R1");
      do_stop();
      rand_read(7'd5, 2, "R1");

      lock_cmd(8'hFD, 1, "R5");
      chk(locked === 1'b0, "R5", "lock with bit1 clear", locked, 0);
      rand_read(7'($urandom), 16, "R5");
      lock_cmd(8'h02, 0, "R4");
      chk(locked === 1'b0, "R4", "discarded lock", locked, 0);
      lock_cmd(8'h02, 1, "R5");
      chk(locked === 1'b1, "R5", "lock taken", locked, 1);

      page_write(7'd3, 4, 1, "R6");
      lock_cmd(8'hFF, 1, "R6");
      rand_read(7'd0, 10, "R7");
      chk(locked === 1'b1, "R6", "lock sticky", locked, 1);

      apply_reset();
      rand_read(7'd60, 8, "R8");

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog run did not end actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule